// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a write-only slave port that loads a bank of 8-bit configuration registers from a serial bitstream. A host lowers an active-low select line and clocks bits in, most significant bit first. The frame carries four things in order: a 7-bit device identifier, a direction bit, a pointer byte, and one or more data bytes. The lower seven bits of the pointer byte choose the target register. The top bit of the pointer byte turns on automatic advance across a burst.

The serial clock has no fixed phase relation to the system clock. The port samples select, serial clock and data through two-flop synchronisers and finds rising serial-clock edges in the system clock domain. Each accepted data byte is written into the internal register bank. The same byte also appears on a one-cycle write strobe with its address and data, so neighbouring logic can track changes. Frames that carry another identifier or request a read leave every register untouched.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset all registers read 0 and the write strobe is low.
- R2: Data is taken on rising serial-clock edges while select is low, most significant bit first. Edges while select is high are ignored.
- R3: The first seven bits of a frame must equal 1001010. On any other value, no register changes for the rest of the frame.
- R4: The eighth bit must be 0 (write). When it is 1, the frame causes no register change and no strobe.
- R5: The ninth to sixteenth bits form the pointer byte. Bits 6:0 of that byte give the register address. The next eight bits are written to that register. The write is announced by a strobe that is high for exactly one system clock, with matching address and data.
- R6: When pointer bit 7 is 1, each further data byte goes to the next address, and address 127 wraps to 0.
- R7: When pointer bit 7 is 0, every data byte in the frame goes to the same register. The last byte remains.
- R8: Raising select ends the frame at once. A data byte with fewer than eight bits received is discarded. The next frame starts again from the identifier.
- R9: With each serial-clock phase lasting at least three system clocks, every complete data byte produces exactly one strobe pulse, and the strobe is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sck | input | 1 | Serial bit clock, asynchronous |
| sdi | input | 1 | Serial data in |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Address of the strobed write |
| wr_data | output | 8 | Data of the strobed write |
| regs_flat | output | 1024 | All registers, register n at bits 8n+7:8n |

## Verification
A wrong bit counter or a misaligned shift register shows up as a wrong value in the target register, or as a write to a neighbouring register, as soon as the first data byte lands. That is about three system clocks after its eighth rising edge. A broken identifier compare or a lost skip state shows up as a strobe pulse during a frame that should be ignored. A fault in pointer advance or wrap shows up across a burst at the 127 to 0 boundary. A missing abort clear shows up as a corrupted byte in the frame that follows.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    parameter int ADDR_W   = 7;
    parameter int DATA_W   = 8;
    parameter int SYNC_LEN = 2;
    parameter int ID_W     = 7;
    localparam int REG_CNT = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam logic [ID_W-1:0] DEVICE_ID = 7'b1001010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIP,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } frame_st_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Header byte accepted only when identifier matches and direction is write
    function automatic logic header_ok(input logic [DATA_W-1:0] hdr);
        return (hdr[DATA_W-1 -: ID_W] == DEVICE_ID) && (hdr[0] == 1'b0);
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{rst_val[g]}};
                else     chain <= {chain[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg_frame.sv
module cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_s,
    input  logic    sck_s,
    input  logic    sdi_s,
    output wr_req_t wr
);
    frame_st_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shift_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              incr_q;
    logic              sck_q;
    logic              sck_rise;
    logic [DATA_W-1:0] byte_now;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_q & ~cs_s;
    assign byte_now = {shift_q[DATA_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shift_q <= '0;
            ptr_q   <= '0;
            incr_q  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (cs_s) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (state == ST_IDLE) begin
                state   <= ST_CHIP;
                bit_cnt <= '0;
            end else if (sck_rise && state != ST_SKIP) begin
                shift_q <= byte_now;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                    unique case (state)
                        ST_CHIP: state <= header_ok(byte_now) ? ST_PTR : ST_SKIP;
                        ST_PTR: begin
                            ptr_q  <= byte_now[ADDR_W-1:0];
                            incr_q <= byte_now[DATA_W-1];
                            state  <= ST_DATA;
                        end
                        ST_DATA: begin
                            wr.en   <= 1'b1;
                            wr.addr <= ptr_q;
                            wr.data <= byte_now;
                            if (incr_q) ptr_q <= ptr_q + 1'b1;
                        end
                        default: state <= ST_SKIP;
                    endcase
                end
            end
        end
    end

    // R3 / R4: a rejected frame never produces a strobe
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |=> !wr.en);
    // R8: strobes only come from cycles where select was low
    p_strobe_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(!cs_s));
    // R7: a fixed pointer stays put during the data phase
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !incr_q && !cs_s) |=> $stable(ptr_q));
    // R6: with advance on, each strobe moves the pointer by one
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && incr_q && state == ST_DATA) |-> (ptr_q == wr.addr + 1'b1));
    // R9: strobe is a single-cycle pulse
    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import spi_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr,
    output logic [REG_CNT*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] mem [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) mem[i] <= '0;
        end else if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < REG_CNT; g++) begin : g_out
            assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
        end
    endgenerate

    // R5: a strobed write lands in the addressed register
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (mem[$past(wr.addr)] == $past(wr.data)));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      sck,
    input  logic                      sdi,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [DATA_W-1:0]         wr_data,
    output logic [REG_CNT*DATA_W-1:0] regs_flat
);
    logic [2:0] pins_s;
    wr_req_t    wr;

    cfg_sync #(.W(3), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     ({cs_n, sck, sdi}),
        .rst_val (3'b100),
        .dout    (pins_s)
    );

    cfg_frame u_frame (
        .clk   (clk),
        .rst   (rst),
        .cs_s  (pins_s[2]),
        .sck_s (pins_s[1]),
        .sdi_s (pins_s[0]),
        .wr    (wr)
    );

    cfg_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .regs_flat (regs_flat)
    );

    assign wr_en   = wr.en;
    assign wr_addr = wr.addr;
    assign wr_data = wr.data;
endmodule

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          wr_en;
    logic [6:0]    wr_addr;
    logic [7:0]    wr_data;
    logic [1023:0] regs_flat;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int double_hi = 0;
    logic       prev_wr = 1'b0;
    logic [6:0] last_addr = '0;
    logic [7:0] last_data = '0;

    always #10 clk = ~clk;

    spi_cfg_port dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                pulses++;
                last_addr = wr_addr;
                last_data = wr_data;
            end
            if (wr_en && prev_wr) double_hi++;
            prev_wr = wr_en;
        end
    end

    function automatic logic [7:0] rd(input int a);
        return regs_flat[a*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_frame();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic t_reset();
        int nz = 0;
        for (int a = 0; a < 128; a++) if (rd(a) != 8'h00) nz++;
        chk("R1 registers zero", nz, 0);
        chk("R1 strobe low", wr_en, 0);
    endtask

    task automatic t_single();
        int p0 = pulses;
        // edges with select high must do nothing
        send_byte(8'hFF);
        wait_clk(6);
        chk("R2 edges ignored with select high", pulses - p0, 0);
        begin_frame();
        send_byte(8'h94);
        send_byte(8'h05);
        send_byte(8'hA5);
        end_frame();
        chk("R2 reg5 value msb first", rd(5), 8'hA5);
        chk("R5 one strobe", pulses - p0, 1);
        chk("R5 strobe address", last_addr, 7'h05);
        chk("R5 strobe data", last_data, 8'hA5);
    endtask

    task automatic t_burst_incr();
        int p0 = pulses;
        begin_frame();
        send_byte(8'h94);
        send_byte(8'hFE);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        end_frame();
        chk("R6 reg126", rd(126), 8'h11);
        chk("R6 reg127", rd(127), 8'h22);
        chk("R6 wrap to reg0", rd(0), 8'h33);
        chk("R9 strobes per byte", pulses - p0, 3);
    endtask

    task automatic t_noincr();
        int p0 = pulses;
        begin_frame();
        send_byte(8'h94);
        send_byte(8'h10);
        send_byte(8'h44);
        send_byte(8'h55);
        end_frame();
        chk("R7 reg16 last byte", rd(16), 8'h55);
        chk("R7 reg17 untouched", rd(17), 8'h00);
        chk("R7 two strobes", pulses - p0, 2);
    endtask

    task automatic t_bad_id();
        int p0 = pulses;
        begin_frame();
        send_byte(8'h96);
        send_byte(8'h20);
        send_byte(8'h99);
        end_frame();
        chk("R3 reg32 untouched", rd(32), 8'h00);
        chk("R3 no strobe", pulses - p0, 0);
    endtask

    task automatic t_read_req();
        int p0 = pulses;
        begin_frame();
        send_byte(8'h95);
        send_byte(8'h21);
        send_byte(8'h5A);
        end_frame();
        chk("R4 reg33 untouched", rd(33), 8'h00);
        chk("R4 no strobe", pulses - p0, 0);
    endtask

    task automatic t_abort();
        int p0 = pulses;
        begin_frame();
        send_byte(8'h94);
        send_byte(8'hB0);
        send_byte(8'h77);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_frame();
        chk("R8 full byte kept", rd(48), 8'h77);
        chk("R8 partial byte dropped", rd(49), 8'h00);
        chk("R8 one strobe", pulses - p0, 1);
        begin_frame();
        send_byte(8'h94);
        send_byte(8'h31);
        send_byte(8'h66);
        end_frame();
        chk("R8 fresh frame after abort", rd(49), 8'h66);
    endtask

    initial begin
        wait_clk(200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_single();
        t_burst_incr();
        t_noincr();
        t_bad_id();
        t_read_req();
        t_abort();
        chk("R9 never two-cycle strobe", double_hi, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule